// File: doc/BRIEF.md
# PWM Script Loader and Launcher

This block serves the three PWM-related commands of a command controller. The controller passes each parameter byte of a command together with its command code and the byte's position in the command. The block stores 16-bit script words in a 256-entry memory. It keeps a start address for each of three PWM channels and issues one-cycle start and stop strobes per channel. A read port lets the script execution engine fetch stored words; the engine itself lies outside this block.

A single parameter byte carries two fields. Bits [1:0] select a channel (value 1 to 3 names channel 0 to 2, and 0 is illegal). Bits [7:2] give a word address, and values above 59 are illegal. The block checks these fields before it writes, starts or stops anything. When it retires a command it tells the controller with a done pulse, and it reports rejected bytes with a bad-parameter pulse in the same cycle.

Top module: `pwm_script_loader`

## Requirements
- R1: After reset all three channel start addresses are zero, and done, bad_par, mem_we and every start and stop strobe are low.
- R2: A script-write command (code 0x95) rejects an index-0 byte whose bits [1:0] are 0 or whose bits [7:2] exceed 59. It then pulses bad_par and done one cycle after the byte and writes no memory.
- R3: An accepted index-0 script-write byte takes the whole byte as the write address and writes zero to that word. mem_we pulses with that address and zero data, and done stays low.
- R4: Index-1 and index-2 bytes of an accepted script write OR into bits [15:8] and [7:0] of the addressed word. Each writes the merged word, and the index-2 byte also pulses done.
- R5: A start command (code 0x96) with a valid byte stores bits [7:2] as the start address of channel (bits[1:0] - 1). It pulses only that channel's start strobe and pulses done.
- R6: A start byte with bits [1:0] equal to 0 or bits [7:2] above 59 pulses bad_par and done. It leaves every start address unchanged and raises no strobe.
- R7: A stop command (code 0x97) pulses done after its byte. If bits [1:0] are 0 it pulses bad_par and no strobe. Otherwise it pulses only the stop strobe of channel (bits[1:0] - 1), whatever bits [7:2] hold.
- R8: Each strobe, done, bad_par and mem_we is high for exactly the one cycle after the accepted parameter byte that caused it. Start and stop are never high together for one channel.
- R9: Bytes carrying any other command code change no output and no stored state.
- R10: Script-write bytes at index 3 are ignored, and so are index-1 or index-2 bytes that arrive with no accepted address byte pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prm_valid | input | 1 | A parameter byte is presented this cycle |
| cmd_code | input | 8 | Command code the byte belongs to |
| prm_idx | input | 2 | Position of the byte within the command |
| prm_byte | input | 8 | Parameter byte |
| rd_addr | input | 8 | Script memory read address |
| rd_data | output | 16 | Script word at rd_addr |
| mem_we | output | 1 | A script word was written |
| mem_waddr | output | 8 | Address of the written word |
| mem_wdata | output | 16 | Value of the written word |
| chan_addr | output | 18 | Start addresses, 6 bits per channel, channel i at [6i+5:6i] |
| start_pls | output | 3 | Per-channel start strobe |
| stop_pls | output | 3 | Per-channel stop strobe |
| bad_par | output | 1 | Rejected parameter byte |
| done | output | 1 | Command retired |

## Verification
The bench targets the edges of the range check: word address 59 against 60, and selector 0 against 3. A design that used the wrong comparison would accept word 60 or refuse word 59, and one that mapped the selector without subtracting one would load or strobe the wrong channel. It also checks OR-merging by sending a second high byte and by re-addressing a used word. A design that overwrote instead of merging, or that did not clear the word, would leave a wrong value at the read port. Stop bytes whose word field is out of range must still strobe, and a design that range-checked them would pulse bad_par instead. Stray data bytes must change nothing at the ports.

// File: rtl/pwmldr_pkg.sv
package pwmldr_pkg;

    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 2;
    localparam int WADR_W  = BYTE_W - SEL_W;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NCH     = (1 << SEL_W) - 1;
    localparam int IDX_W   = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_START = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef struct packed {
        logic [WADR_W-1:0] waddr;
        logic [SEL_W-1:0]  sel;
    } pbyte_t;

    typedef struct packed {
        logic mem_clear;
        logic mem_hi;
        logic mem_lo;
        logic do_start;
        logic do_stop;
        logic bad;
        logic retire;
        logic drop_pend;
    } action_t;

    function automatic logic sel_legal(input pbyte_t b);
        return b.sel != '0;
    endfunction

    function automatic logic addr_legal(input pbyte_t b, input int unsigned max_w);
        return (b.sel != '0) && (32'(b.waddr) <= max_w);
    endfunction

    function automatic logic [SEL_W-1:0] chan_of(input pbyte_t b);
        return b.sel - 1'b1;
    endfunction

endpackage

// File: rtl/pwmldr_decode.sv
module pwmldr_decode
    import pwmldr_pkg::*;
#(
    parameter logic [7:0] CODE_WRITE = 8'h95,
    parameter logic [7:0] CODE_START = 8'h96,
    parameter logic [7:0] CODE_STOP  = 8'h97,
    parameter int unsigned MAX_WADDR = 59
) (
    input  logic              prm_valid,
    input  logic [7:0]        cmd_code,
    input  logic [IDX_W-1:0]  prm_idx,
    input  pbyte_t            pb,
    input  logic              pend,
    output action_t           act
);

    op_e op;

    always_comb begin
        if (!prm_valid)                 op = OP_NONE;
        else if (cmd_code == CODE_WRITE) op = OP_WRITE;
        else if (cmd_code == CODE_START) op = OP_START;
        else if (cmd_code == CODE_STOP)  op = OP_STOP;
        else                             op = OP_NONE;
    end

    always_comb begin
        act = '0;
        unique case (op)
            OP_WRITE: begin
                unique case (prm_idx)
                    2'd0: begin
                        if (addr_legal(pb, MAX_WADDR)) begin
                            act.mem_clear = 1'b1;
                        end else begin
                            act.bad       = 1'b1;
                            act.retire    = 1'b1;
                            act.drop_pend = 1'b1;
                        end
                    end
                    2'd1: act.mem_hi = pend;
                    2'd2: begin
                        act.mem_lo    = pend;
                        act.retire    = pend;
                        act.drop_pend = 1'b1;
                    end
                    default: ;
                endcase
            end
            OP_START: begin
                act.retire    = 1'b1;
                act.drop_pend = 1'b1;
                if (addr_legal(pb, MAX_WADDR)) act.do_start = 1'b1;
                else                            act.bad      = 1'b1;
            end
            OP_STOP: begin
                act.retire    = 1'b1;
                act.drop_pend = 1'b1;
                if (sel_legal(pb)) act.do_stop = 1'b1;
                else               act.bad     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwmldr_wordbuf.sv
module pwmldr_wordbuf
    import pwmldr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  action_t            act,
    input  logic [BYTE_W-1:0]  pbyte,
    output logic               pend,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_addr,
    output logic [WORD_W-1:0]  wr_data,
    output logic               mem_we,
    output logic [BYTE_W-1:0]  mem_waddr,
    output logic [WORD_W-1:0]  mem_wdata
);

    logic [BYTE_W-1:0] addr_q;
    logic [WORD_W-1:0] word_q;

    always_comb begin
        wr_en   = act.mem_clear | act.mem_hi | act.mem_lo;
        wr_addr = act.mem_clear ? pbyte : addr_q;
        if (act.mem_clear)   wr_data = '0;
        else if (act.mem_hi) wr_data = word_q | {pbyte, {BYTE_W{1'b0}}};
        else if (act.mem_lo) wr_data = word_q | {{BYTE_W{1'b0}}, pbyte};
        else                 wr_data = word_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            addr_q    <= '0;
            word_q    <= '0;
            mem_we    <= 1'b0;
            mem_waddr <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= wr_en;
            if (wr_en) begin
                addr_q    <= wr_addr;
                word_q    <= wr_data;
                mem_waddr <= wr_addr;
                mem_wdata <= wr_data;
            end
            if (act.mem_clear)      pend <= 1'b1;
            else if (act.drop_pend) pend <= 1'b0;
        end
    end

endmodule

// File: rtl/pwmldr_mem.sv
module pwmldr_mem
    import pwmldr_pkg::*;
#(
    parameter int DEPTH = 1 << BYTE_W
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [BYTE_W-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [BYTE_W-1:0]  rd_addr,
    output logic [WORD_W-1:0]  rd_data
);

    logic [WORD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/pwmldr_chan.sv
module pwmldr_chan
    import pwmldr_pkg::*;
#(
    parameter int CH = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  action_t            act,
    input  pbyte_t             pb,
    output logic [WADR_W-1:0]  start_addr,
    output logic               start_pls,
    output logic               stop_pls
);

    logic hit;
    assign hit = (chan_of(pb) == SEL_W'(CH)) && sel_legal(pb);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_addr <= '0;
            start_pls  <= 1'b0;
            stop_pls   <= 1'b0;
        end else begin
            start_pls <= act.do_start & hit;
            stop_pls  <= act.do_stop & hit & ~act.do_start;
            if (act.do_start && hit) start_addr <= pb.waddr;
        end
    end

endmodule

// File: rtl/pwm_script_loader.sv
module pwm_script_loader
    import pwmldr_pkg::*;
#(
    parameter logic [7:0] CODE_WRITE = 8'h95,
    parameter logic [7:0] CODE_START = 8'h96,
    parameter logic [7:0] CODE_STOP  = 8'h97,
    parameter int unsigned MAX_WADDR = 59
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    prm_valid,
    input  logic [7:0]              cmd_code,
    input  logic [1:0]              prm_idx,
    input  logic [7:0]              prm_byte,
    input  logic [7:0]              rd_addr,
    output logic [15:0]             rd_data,
    output logic                    mem_we,
    output logic [7:0]              mem_waddr,
    output logic [15:0]             mem_wdata,
    output logic [17:0]             chan_addr,
    output logic [2:0]              start_pls,
    output logic [2:0]              stop_pls,
    output logic                    bad_par,
    output logic                    done
);

    action_t             act;
    pbyte_t              pb;
    logic                pend;
    logic                wr_en;
    logic [BYTE_W-1:0]   wr_addr;
    logic [WORD_W-1:0]   wr_data;

    assign pb = pbyte_t'(prm_byte);

    pwmldr_decode #(
        .CODE_WRITE (CODE_WRITE),
        .CODE_START (CODE_START),
        .CODE_STOP  (CODE_STOP),
        .MAX_WADDR  (MAX_WADDR)
    ) u_dec (
        .prm_valid (prm_valid),
        .cmd_code  (cmd_code),
        .prm_idx   (prm_idx),
        .pb        (pb),
        .pend      (pend),
        .act       (act)
    );

    pwmldr_wordbuf u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .pbyte     (prm_byte),
        .pend      (pend),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    pwmldr_mem u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwmldr_chan #(.CH(g)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .act        (act),
            .pb         (pb),
            .start_addr (chan_addr[g*WADR_W +: WADR_W]),
            .start_pls  (start_pls[g]),
            .stop_pls   (stop_pls[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_par <= 1'b0;
            done    <= 1'b0;
        end else begin
            bad_par <= act.bad;
            done    <= act.retire;
        end
    end

endmodule

// File: rtl/pwm_script_loader_chk.sv
module pwm_script_loader_chk (
    input logic        clk,
    input logic        rst,
    input logic        prm_valid,
    input logic        mem_we,
    input logic [17:0] chan_addr,
    input logic [2:0]  start_pls,
    input logic [2:0]  stop_pls,
    input logic        bad_par,
    input logic        done
);

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !bad_par && !mem_we && start_pls == 3'b0 && stop_pls == 3'b0 && chan_addr == 18'b0)); // R1

    AST_BAD_RETIRES: assert property (@(posedge clk) disable iff (rst)
        bad_par |-> done); // R2

    AST_WE_FROM_BYTE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(prm_valid)); // R3

    AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_pls)); // R5

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(prm_valid) |-> $stable(chan_addr)); // R6

    AST_ONE_STOP: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stop_pls)); // R7

    AST_STROBE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (start_pls != 3'b0 || stop_pls != 3'b0 || done) |-> $past(prm_valid)); // R8

    AST_NO_START_STOP: assert property (@(posedge clk) disable iff (rst)
        (start_pls & stop_pls) == 3'b0); // R8

endmodule

bind pwm_script_loader pwm_script_loader_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .prm_valid (prm_valid),
    .mem_we    (mem_we),
    .chan_addr (chan_addr),
    .start_pls (start_pls),
    .stop_pls  (stop_pls),
    .bad_par   (bad_par),
    .done      (done)
);

// File: tb/pwm_script_loader_test.sv
module pwm_script_loader_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prm_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [1:0]  prm_idx = 2'd0;
    logic [7:0]  prm_byte = 8'h00;
    logic [7:0]  rd_addr = 8'h00;
    logic [15:0] rd_data;
    logic        mem_we;
    logic [7:0]  mem_waddr;
    logic [15:0] mem_wdata;
    logic [17:0] chan_addr;
    logic [2:0]  start_pls;
    logic [2:0]  stop_pls;
    logic        bad_par;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pwm_script_loader uut (
        .clk       (clk),
        .rst       (rst),
        .prm_valid (prm_valid),
        .cmd_code  (cmd_code),
        .prm_idx   (prm_idx),
        .prm_byte  (prm_byte),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .chan_addr (chan_addr),
        .start_pls (start_pls),
        .stop_pls  (stop_pls),
        .bad_par   (bad_par),
        .done      (done)
    );

    // {code, idx, byte, done, bad, we, start[2:0], stop[2:0]}
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {8'h95, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, 3'b000}, // R2 selector 0
        {8'h95, 2'd0, 8'hF1, 1'b1, 1'b1, 1'b0, 3'b000, 3'b000}, // R2 word 60
        {8'h95, 2'd0, 8'hED, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000}, // R3 word 59 accepted
        {8'h95, 2'd1, 8'hAB, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000}, // R4 high byte
        {8'h95, 2'd2, 8'hCD, 1'b1, 1'b0, 1'b1, 3'b000, 3'b000}, // R4 low byte
        {8'h95, 2'd1, 8'h11, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000}, // R10 no pending
        {8'h95, 2'd3, 8'h22, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000}, // R10 index 3
        {8'h96, 2'd0, 8'h00, 1'b1, 1'b1, 1'b0, 3'b000, 3'b000}, // R6 selector 0
        {8'h96, 2'd0, 8'h06, 1'b1, 1'b0, 1'b0, 3'b010, 3'b000}, // R5 channel 1
        {8'h97, 2'd0, 8'hFC, 1'b1, 1'b1, 1'b0, 3'b000, 3'b000}, // R7 selector 0
        {8'h97, 2'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 3'b000, 3'b100}, // R7 word field ignored
        {8'h42, 2'd0, 8'h05, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000}  // R9 foreign code
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic [1:0] i, input logic [7:0] b);
        @(negedge clk);
        prm_valid = 1'b1;
        cmd_code  = c;
        prm_idx   = i;
        prm_byte  = b;
        @(negedge clk);
        prm_valid = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #1;
        chk(32'(rd_data), 32'(exp), tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(32'(chan_addr), 32'h0, "R1 chan_addr");
        chk(32'({done, bad_par, mem_we}), 32'h0, "R1 done/bad/we");
        chk(32'({start_pls, stop_pls}), 32'h0, "R1 strobes");

        for (int k = 0; k < NV; k++) begin
            send(VEC[k][26:19], VEC[k][18:17], VEC[k][16:9]);
            chk(32'(done),      32'(VEC[k][8]),   $sformatf("vec%0d done R2/R4/R5/R7", k));
            chk(32'(bad_par),   32'(VEC[k][7]),   $sformatf("vec%0d bad_par R2/R6/R7", k));
            chk(32'(mem_we),    32'(VEC[k][6]),   $sformatf("vec%0d mem_we R3/R4/R10", k));
            chk(32'(start_pls), 32'(VEC[k][5:3]), $sformatf("vec%0d start R5 R9", k));
            chk(32'(stop_pls),  32'(VEC[k][2:0]), $sformatf("vec%0d stop R7", k));
            // R8: strobes last one cycle
            @(negedge clk);
            chk(32'({done, bad_par, mem_we, start_pls, stop_pls}), 32'h0,
                $sformatf("vec%0d R8 one-cycle", k));
        end

        // R4 word merged at word 59 channel-1 address
        peek(8'hED, 16'hABCD, "R4 merged word");
        // R10 stray bytes did not touch it; R9 foreign code left channels
        chk(32'(chan_addr), 32'({6'd0, 6'd1, 6'd0}), "R5 ch1 addr R9");

        // R5 channel 2, address 59
        send(8'h96, 2'd0, 8'hEF);
        chk(32'(start_pls), 32'h4, "R5 ch2 strobe");
        chk(32'(chan_addr), 32'({6'd59, 6'd1, 6'd0}), "R5 ch2 addr");
        // R6 word 60 rejected, addresses unchanged
        send(8'h96, 2'd0, 8'hF2);
        chk(32'({bad_par, done, start_pls}), 32'h6 << 2, "R6 bad start");
        chk(32'(chan_addr), 32'({6'd59, 6'd1, 6'd0}), "R6 addr unchanged");
        // R5 channel 0, address 0
        send(8'h96, 2'd0, 8'h01);
        chk(32'(start_pls), 32'h1, "R5 ch0 strobe");
        chk(32'(chan_addr), 32'({6'd59, 6'd1, 6'd0}), "R5 ch0 addr zero");

        // R3 re-addressing clears a used word
        send(8'h95, 2'd0, 8'hED);
        chk(32'({mem_waddr, mem_wdata}), 32'({8'hED, 16'h0000}), "R3 write port");
        peek(8'hED, 16'h0000, "R3 word cleared");
        send(8'h95, 2'd1, 8'h00);
        send(8'h95, 2'd2, 8'h00);

        // R4 OR behaviour with a repeated high byte
        send(8'h95, 2'd0, 8'h05);
        send(8'h95, 2'd1, 8'h12);
        send(8'h95, 2'd1, 8'h40);
        chk(32'(mem_wdata), 32'h5200, "R4 high OR");
        send(8'h95, 2'd2, 8'h03);
        chk(32'({done, mem_wdata}), 32'({1'b1, 16'h5203}), "R4 low OR done");
        peek(8'h05, 16'h5203, "R4 stored");
        // R10 late low byte after completion ignored
        send(8'h95, 2'd2, 8'hF0);
        chk(32'({done, mem_we}), 32'h0, "R10 late byte");
        peek(8'h05, 16'h5203, "R10 word kept");

        // R7 stop channel 0
        send(8'h97, 2'd0, 8'h01);
        chk(32'({stop_pls, start_pls}), 32'h08, "R7 stop ch0");

        // R1 reset again clears addresses
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(32'(chan_addr), 32'h0, "R1 addr after reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule